// File: doc/BRIEF.md
# Nonvolatile Page Write Sequencer

This block carries out one block-transfer request against a small on-chip nonvolatile array organised in 64-byte pages. A request names a byte count, a source address in a RAM, a destination byte in the array and a two-bit operation. The sequencer does one of three things. It can copy the run of bytes from the RAM into the addressed page, either replacing the old bytes or only clearing bits. It can erase the whole page to all ones. It can also store a byte into the per-page protection store, and writing the lock code to that store makes the page permanently read-only.

Copying is done first. The source bytes are fetched through a simple combinational RAM read port, one per request clock, into an internal stage. After that come the timed phases. An erase phase and a program phase each last a fixed number of ticks of a separate timebase enable, so their length does not follow the request clock. The array changes only at the end of a phase. A request that cannot be honoured leaves the array untouched and raises an error flag. Reset aborts any operation in flight.

Top module: `eeprom_page_seq`

## Requirements
- R1: A `start` pulse while `busy` is low with an acceptable request makes `busy` high from the next clock edge until the last timed phase ends; `start` pulses while `busy` is high have no effect on the array, the counters or the flags.
- R2: For a copy request the byte count must be 1 to 64; on completion `cnt_out` is 0 and `src_out` equals the start source address plus the count, modulo the RAM address space.
- R3: A copy request whose bytes would run past the end of the destination page (page offset plus count above 64) is rejected.
- R4: With `prot_sel` = 1, `op_mode` 2'b00 (rewrite) runs an erase phase over the addressed bytes and then a program phase, leaving each addressed byte equal to its source byte; the other bytes of the page are unchanged.
- R5: With `prot_sel` = 1, `op_mode` 2'b01 (overwrite) runs only a program phase and leaves each addressed byte equal to its old value AND the source byte.
- R6: With `prot_sel` = 1, `op_mode` 2'b10 (page erase) sets all 64 bytes of the page holding `dst_addr` to 8'hFF; `byte_cnt` and `src_addr` are ignored and `cnt_out` and `src_out` keep their values.
- R7: `op_mode` 2'b11 is the disabled code; such a request is rejected.
- R8: With `prot_sel` = 0 and `op_mode` 2'b00 or 2'b01, the byte at RAM `src_addr` goes into the protection store of the page holding `dst_addr`; `cnt_out` ends at 0 and `src_out` at `src_addr`+1. Bit p of `page_locked` is 1 exactly when page p holds 8'h78, it never returns to 0, and every later request to a locked page is rejected.
- R9: With `prot_sel` = 0, `op_mode` 2'b10 or 2'b11 is rejected.
- R10: Each timed phase ends on its PHASE_TICKS-th `tick` high at a clock edge, so a page erase keeps `busy` high for exactly PHASE_TICKS ticks, whatever the tick spacing in clocks.
- R11: `rst_n` low clears `busy`, `err`, `cnt_out` and `src_out` at once and abandons the operation. A new request is accepted afterwards.
- R12: A rejected request leaves the array, the protection store, `cnt_out` and `src_out` unchanged, keeps `busy` low and sets `err`; the next accepted request clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Request clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable for the timed phases |
| start | input | 1 | Request strobe |
| op_mode | input | 2 | Operation: 00 rewrite, 01 overwrite, 10 page erase, 11 disabled |
| prot_sel | input | 1 | 1 selects the data area, 0 the protection store |
| byte_cnt | input | 7 | Bytes to transfer |
| src_addr | input | 10 | First RAM source address |
| dst_addr | input | 9 | First destination byte in the array |
| ram_addr | output | 10 | RAM read address |
| ram_rdata | input | 8 | RAM read data, same cycle |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Array read data |
| page_locked | output | 8 | Per-page lock status |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Last request was rejected |
| cnt_out | output | 7 | Remaining byte count |
| src_out | output | 10 | Current source address |

## Verification
The hardest situations to reach are the ones that exist only inside a running operation. These are a second strobe arriving mid-operation and a reset landing between the fetch and the commit. For both, the bench waits until `busy` is seen high and then acts at a chosen clock. It pulses a conflicting erase request at the same page, or drops `rst_n` while the page is still being fetched. The permanent lock is reached by first storing a harmless byte and then the lock code from prepared RAM locations. Every kind of request is then retried against the locked page, and its full contents are read back through the array port.

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq #(
  parameter int PAGE_BYTES = 64,
  parameter int NUM_PAGES = 8,
  parameter int RAM_AW = 10,
  parameter int PHASE_TICKS = 4,
  parameter logic [7:0] LOCK_CODE = 8'h78,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int PG_W = $clog2(NUM_PAGES),
  localparam int ARR_AW = OFF_W + PG_W,
  localparam int CNT_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [1:0]        op_mode,
  input  logic              prot_sel,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [RAM_AW-1:0] src_addr,
  input  logic [ARR_AW-1:0] dst_addr,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [7:0]        ram_rdata,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [NUM_PAGES-1:0] page_locked,
  output logic              busy,
  output logic              err,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [RAM_AW-1:0] src_out
);
  localparam int TK_W = $clog2(PHASE_TICKS + 1);
  localparam logic [CNT_W:0] PG_LIM = PAGE_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ERASE, S_PROG} st_t;

  logic [7:0] mem [NUM_PAGES*PAGE_BYTES] = '{default: 8'hFF};
  logic [7:0] lockb [NUM_PAGES] = '{default: 8'h00};
  logic [7:0] stage_q [PAGE_BYTES];

  st_t              st;
  logic [1:0]       md_q;
  logic             psel_q;
  logic [PG_W-1:0]  pg_q;
  logic [OFF_W-1:0] pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RAM_AW-1:0] src_q;
  logic             err_q;
  logic [TK_W-1:0]  tk_q;
  logic [PAGE_BYTES-1:0] sel_q;
  logic             req_ok;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_lock
    assign page_locked[g] = (lockb[g] == LOCK_CODE);
  end

  wire [PG_W-1:0]  req_pg  = dst_addr[ARR_AW-1:OFF_W];
  wire [OFF_W-1:0] req_off = dst_addr[OFF_W-1:0];
  wire [CNT_W:0]   req_end = {2'b00, req_off} + {1'b0, byte_cnt};
  wire             len_ok  = (byte_cnt != '0) && (req_end <= PG_LIM);
  wire             load_last = (cnt_q == CNT_W'(1));
  wire             phase_end = tick && (tk_q == TK_W'(PHASE_TICKS - 1));

  always_comb begin
    if (page_locked[req_pg])  req_ok = 1'b0;
    else if (!prot_sel)       req_ok = !op_mode[1];
    else if (op_mode == 2'b11) req_ok = 1'b0;
    else if (op_mode == 2'b10) req_ok = 1'b1;
    else                      req_ok = len_ok;
  end

  assign busy     = (st != S_IDLE);
  assign err      = err_q;
  assign cnt_out  = cnt_q;
  assign src_out  = src_q;
  assign ram_addr = src_q;
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      md_q   <= 2'b00;
      psel_q <= 1'b1;
      pg_q   <= '0;
      pos_q  <= '0;
      cnt_q  <= '0;
      src_q  <= '0;
      err_q  <= 1'b0;
      tk_q   <= '0;
      sel_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (req_ok) begin
            err_q  <= 1'b0;
            md_q   <= op_mode;
            psel_q <= prot_sel;
            pg_q   <= req_pg;
            pos_q  <= prot_sel ? req_off : '0;
            tk_q   <= '0;
            if (prot_sel && op_mode == 2'b10) begin
              sel_q <= '1;
              st    <= S_ERASE;
            end else begin
              sel_q <= '0;
              cnt_q <= prot_sel ? byte_cnt : CNT_W'(1);
              src_q <= src_addr;
              st    <= S_LOAD;
            end
          end else begin
            err_q <= 1'b1;
          end
        end
        S_LOAD: begin
          sel_q[pos_q] <= 1'b1;
          pos_q <= pos_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          src_q <= src_q + 1'b1;
          if (load_last) st <= (psel_q && md_q == 2'b00) ? S_ERASE : S_PROG;
        end
        S_ERASE: if (tick) begin
          tk_q <= phase_end ? '0 : tk_q + 1'b1;
          if (phase_end) st <= (md_q == 2'b10) ? S_IDLE : S_PROG;
        end
        S_PROG: if (tick) begin
          tk_q <= phase_end ? '0 : tk_q + 1'b1;
          if (phase_end) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_LOAD) stage_q[pos_q] <= ram_rdata;
    if (st == S_ERASE && phase_end) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (sel_q[j]) mem[{pg_q, OFF_W'(j)}] <= 8'hFF;
    end
    if (st == S_PROG && phase_end) begin
      if (psel_q) begin
        for (int j = 0; j < PAGE_BYTES; j++)
          if (sel_q[j]) mem[{pg_q, OFF_W'(j)}] <= mem[{pg_q, OFF_W'(j)}] & stage_q[j];
      end else begin
        lockb[pg_q] <= stage_q[0];
      end
    end
  end
endmodule

// File: rtl/eeprom_page_seq_chk.sv
module eeprom_page_seq_chk #(
  parameter int PAGE_BYTES = 64,
  parameter int NUM_PAGES = 8,
  parameter int CNT_W = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 start,
  input logic                 busy,
  input logic                 err,
  input logic [CNT_W-1:0]     cnt_out,
  input logic [NUM_PAGES-1:0] page_locked
);
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_out <= CNT_W'(PAGE_BYTES)); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (page_locked & $past(page_locked)) == $past(page_locked)); // R8
  AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(tick)); // R10
  AST_ERR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> !busy); // R12
endmodule

bind eeprom_page_seq eeprom_page_seq_chk #(
  .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .busy(busy),
  .err(err), .cnt_out(cnt_out), .page_locked(page_locked)
);

// File: tb/eeprom_page_seq_test.sv
module eeprom_page_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PT = 4;

  logic clk = 0, rst_n = 0, tick = 0, start = 0, prot_sel = 1;
  logic [1:0] op_mode = 0;
  logic [6:0] byte_cnt = 0;
  logic [9:0] src_addr = 0, ram_addr, src_out;
  logic [8:0] dst_addr = 0, rd_addr = 0;
  logic [7:0] ram_rdata, rd_data;
  logic [7:0] page_locked;
  logic busy, err;
  logic [6:0] cnt_out;

  eeprom_page_seq #(.PHASE_TICKS(PT)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .op_mode(op_mode),
    .prot_sel(prot_sel), .byte_cnt(byte_cnt), .src_addr(src_addr), .dst_addr(dst_addr),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .page_locked(page_locked), .busy(busy), .err(err), .cnt_out(cnt_out), .src_out(src_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] ram [1024];
  assign ram_rdata = ram[ram_addr];

  int tick_div = 3;
  initial forever begin
    repeat (tick_div - 1) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  end

  int busy_ticks = 0;
  always @(posedge clk) if (busy && tick) busy_ticks++;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_mem [512];
  logic [7:0] m_lock [8];
  int cnt_m = 0, src_m = 0, err_m = 0;

  typedef struct { int kind; int idx; int exp; string tag; } sb_item_t;
  sb_item_t sbq[$];
  event sb_go;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(int kind, int idx, int exp, string tag);
    sb_item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  initial forever begin
    @(sb_go);
    while (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      case (it.kind)
        0: begin rd_addr = 9'(it.idx); #1; check(it.tag, int'(rd_data), it.exp); end
        1: check(it.tag, int'(err), it.exp);
        2: check(it.tag, int'(cnt_out), it.exp);
        3: check(it.tag, int'(src_out), it.exp);
        default: check(it.tag, int'(page_locked[it.idx]), it.exp);
      endcase
    end
  end

  task automatic run_op(logic [1:0] m, logic ps, int cnt, int src, int dst, string tag, bit poke);
    int page = dst / 64, off = dst % 64;
    bit locked = (m_lock[page] == 8'h78);
    bit ok;
    if (locked) ok = 0;
    else if (!ps) ok = (m < 2);
    else if (m == 3) ok = 0;
    else if (m == 2) ok = 1;
    else ok = (cnt >= 1) && (off + cnt <= 64);
    if (ok) begin
      err_m = 0;
      if (ps && m == 2) begin
        for (int i = 0; i < 64; i++) m_mem[page*64+i] = 8'hFF;
      end else if (!ps) begin
        m_lock[page] = ram[src];
        cnt_m = 0; src_m = (src + 1) % 1024;
      end else begin
        for (int i = 0; i < cnt; i++) begin
          logic [7:0] d = ram[(src + i) % 1024];
          m_mem[page*64+off+i] = (m == 0) ? d : (m_mem[page*64+off+i] & d);
        end
        cnt_m = 0; src_m = (src + cnt) % 1024;
      end
    end else err_m = 1;
    for (int i = 0; i < 64; i++) push(0, page*64+i, int'(m_mem[page*64+i]), tag);
    push(1, 0, err_m, "R12");
    push(2, 0, cnt_m, "R2");
    push(3, 0, src_m, "R2");
    for (int p = 0; p < 8; p++) push(4, p, int'(m_lock[p] == 8'h78), "R8");

    @(negedge clk);
    op_mode = m; prot_sel = ps; byte_cnt = 7'(cnt); src_addr = 10'(src); dst_addr = 9'(dst);
    start = 1; busy_ticks = 0;
    @(negedge clk);
    start = 0;
    check("R1", int'(busy), int'(ok));
    if (poke && ok) begin
      op_mode = 2'b10; prot_sel = 1; byte_cnt = 7'd1; src_addr = 10'd5;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    if (ok && ps && m == 2) check("R10", busy_ticks, PT);
    ->sb_go;
    wait (sbq.size() == 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    report();
  end

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 8'((i * 37 + 5) & 255);
    ram[1000] = 8'h78;
    ram[1001] = 8'h12;
    for (int i = 0; i < 512; i++) m_mem[i] = 8'hFF;
    for (int p = 0; p < 8; p++) m_lock[p] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11", int'(busy), 0);
    check("R11", int'(err), 0);
    check("R11", int'(cnt_out), 0);
    check("R11", int'(src_out), 0);
    check("R8", int'(page_locked), 0);

    for (int p = 0; p < 8; p++) run_op(2'b10, 1, 3, 40, p*64 + 7, "R6", 0);
    run_op(2'b00, 1, 64, 0, 64, "R4", 0);
    run_op(2'b00, 1, 5, 100, 128 + 10, "R4", 0);
    run_op(2'b01, 1, 8, 200, 128 + 12, "R5", 0);
    run_op(2'b00, 1, 4, 1020, 192 + 60, "R2", 0);
    run_op(2'b10, 1, 0, 777, 64 + 33, "R6", 0);
    run_op(2'b00, 1, 5, 10, 192 + 60, "R3", 0);
    run_op(2'b00, 1, 0, 10, 0, "R2", 0);
    run_op(2'b01, 1, 65, 10, 0, "R2", 0);
    run_op(2'b11, 1, 4, 10, 0, "R7", 0);
    run_op(2'b01, 1, 3, 50, 0, "R5", 0);
    run_op(2'b00, 1, 8, 300, 384, "R1", 1);
    tick_div = 7;
    run_op(2'b10, 1, 9, 0, 384, "R10", 0);
    tick_div = 3;

    run_op(2'b00, 0, 1, 1001, 320, "R8", 0);
    run_op(2'b00, 1, 6, 400, 320 + 2, "R8", 0);
    run_op(2'b01, 0, 1, 1000, 320, "R8", 0);
    run_op(2'b00, 1, 6, 500, 320 + 2, "R8", 0);
    run_op(2'b10, 1, 1, 0, 320, "R8", 0);
    run_op(2'b00, 0, 1, 1001, 320, "R8", 0);
    run_op(2'b10, 0, 1, 1001, 256, "R9", 0);
    run_op(2'b11, 0, 1, 1001, 256, "R9", 0);

    @(negedge clk);
    op_mode = 2'b00; prot_sel = 1; byte_cnt = 7'd16; src_addr = 10'd600; dst_addr = 9'd256;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    check("R11", int'(busy), 1);
    rst_n = 0;
    #1;
    check("R11", int'(busy), 0);
    check("R11", int'(cnt_out), 0);
    check("R11", int'(src_out), 0);
    check("R11", int'(err), 0);
    @(negedge clk);
    rst_n = 1;
    cnt_m = 0; src_m = 0; err_m = 0;
    run_op(2'b10, 1, 1, 0, 256, "R11", 0);
    run_op(2'b01, 1, 2, 700, 256 + 62, "R11", 0);

    report();
  end
endmodule